// File: doc/BRIEF.md
# Hypercube Dimension-Order Cut-Through Router

This block is one node's switch in a binary hypercube of `DIM` dimensions. Every link carries one bit per clock with a valid flag, an end-of-message flag and a ready signal that runs back to the sender. One serial input and one serial output exist per dimension, plus a local inject input and a local eject output. Each message opens with a fixed header of `HDR_W` bits (36 by default), sent least significant bit first. The destination node address sits in the lowest `DIM` bits of that header. The header is forwarded untouched, and long transfers are cut by the sender into segments that each carry their own header.

An input channel collects the header while its ready stays high. As soon as the last header bit is in, it chooses an output. If the destination equals the node's own address, the message goes to the eject port. Otherwise it goes to the link of the lowest-numbered dimension in which the two addresses differ. The channel then asks that output for ownership, replays the stored header, and passes the remaining bits straight through. Nothing waits for the full message to arrive. An output stays with one input until that message's end marker has been transferred, and contending inputs take turns in round-robin order. A stalled output drops the ready of the input that owns it, so no bit is ever lost.

Input channel states: `RX_HDR` collects the header. `RX_HEAD` requests the output and replays the header. `RX_BODY` passes bits through. The transitions are: header complete (`RX_HDR`→`RX_HEAD`), header replayed (`RX_HEAD`→`RX_BODY`) and end marker passed (`RX_BODY`→`RX_HDR`). Output channel states: `OUT_FREE` and `OUT_HELD`, with the transitions grant (`OUT_FREE`→`OUT_HELD`, taken when any input requests) and release (`OUT_HELD`→`OUT_FREE`, taken when the owner's end marker is transferred).

Top module: `hcube_router`

## Requirements
- R1: After reset, every output valid (link outputs and eject) is low and every input ready (links and inject) is high.
- R2: A message whose destination field (header bits [DIM-1:0]) equals `node_id` leaves on the eject port.
- R3: Any other message leaves on link output k, where k is the lowest bit position in which the destination field and `node_id` differ.
- R4: The forwarded message is bit-for-bit identical to the received one, header included, in the same order (LSB first), with the end marker only on its final bit.
- R5: If the chosen output is free, the output valid rises no later than two clock cycles after the clock edge that accepts the final header bit.
- R6: An output, once granted, carries only one message until that message's end marker has been transferred, so messages are never interleaved.
- R7: Inputs contending for one output are served round-robin, with the search starting at the input just after the previous owner of that output.
- R8: While an output is not ready, its valid, bit and end marker hold steady, the owning input is stalled, and no bit is dropped or repeated.
- R9: Messages that go from different inputs to different outputs advance at the same time and do not delay each other.
- R10: Consecutive segments on one input are each routed by their own header.
- R11: An end marker that arrives together with a header bit is ignored; the message ends only at the first end marker after the header.
- R12: While a header is being collected, the input ready stays high, so header bits are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | DIM | Address of this node |
| lk_in_bit | input | DIM | Serial data bit per incoming link |
| lk_in_vld | input | DIM | Valid per incoming link |
| lk_in_eom | input | DIM | End-of-message marker per incoming link |
| lk_in_rdy | output | DIM | Ready back to each incoming link |
| lk_out_bit | output | DIM | Serial data bit per outgoing link |
| lk_out_vld | output | DIM | Valid per outgoing link |
| lk_out_eom | output | DIM | End-of-message marker per outgoing link |
| lk_out_rdy | input | DIM | Ready from each outgoing link |
| inj_bit | input | 1 | Local inject data bit |
| inj_vld | input | 1 | Local inject valid |
| inj_eom | input | 1 | Local inject end-of-message marker |
| inj_rdy | output | 1 | Local inject ready |
| ej_bit | output | 1 | Local eject data bit |
| ej_vld | output | 1 | Local eject valid |
| ej_eom | output | 1 | Local eject end-of-message marker |
| ej_rdy | input | 1 | Local eject ready |

## Verification
The bench uses destination fields that match the node, that differ only in a high bit, and that differ in several bits at once. These show whether the eject decision and the lowest-differing-dimension rule are both taken from the right header bits. Two inputs that target one output right after a third input has used it give different orders under round-robin and under fixed priority. Two inputs that target different outputs at the same time reveal any hidden shared resource. Ready patterns that toggle and that are held low, together with an end marker placed inside the header, test whether any bit is lost, repeated or cut short.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [1:0] {
        RX_HDR  = 2'd0,
        RX_HEAD = 2'd1,
        RX_BODY = 2'd2
    } rx_state_e;

    typedef enum logic {
        OUT_FREE = 1'b0,
        OUT_HELD = 1'b1
    } out_state_e;

endpackage

// File: rtl/hcr_in_chan.sv
module hcr_in_chan
    import hcr_pkg::*;
#(
    parameter int DIM   = 3,
    parameter int HDR_W = 36,
    parameter int PW    = $clog2(DIM + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIM-1:0] node_id,
    input  logic           in_bit,
    input  logic           in_vld,
    input  logic           in_eom,
    output logic           in_rdy,
    output logic           req,
    output logic [PW-1:0]  tgt,
    input  logic           gnt,
    output logic           tx_bit,
    output logic           tx_vld,
    output logic           tx_eom,
    input  logic           tx_rdy
);

    localparam int CW = $clog2(HDR_W);
    localparam logic [CW-1:0] LAST = CW'(HDR_W - 1);

    rx_state_e        st, st_nx;
    logic [CW-1:0]    cnt, cnt_nx;
    logic [HDR_W-1:0] hdr, hdr_nx;
    logic [PW-1:0]    tgt_q, tgt_nx;

    // lowest differing dimension, or the local port when none differs
    function automatic logic [PW-1:0] pick_port(input logic [DIM-1:0] dst,
                                                input logic [DIM-1:0] me);
        logic [DIM-1:0] diff;
        logic [PW-1:0]  res;
        diff = dst ^ me;
        res  = PW'(DIM);
        for (int k = DIM - 1; k >= 0; k--) begin
            if (diff[k]) res = PW'(k);
        end
        return res;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_HDR;
            cnt   <= '0;
            hdr   <= '0;
            tgt_q <= '0;
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            hdr   <= hdr_nx;
            tgt_q <= tgt_nx;
        end
    end

    // next state and header datapath
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        hdr_nx = hdr;
        tgt_nx = tgt_q;
        unique case (st)
            RX_HDR: begin
                if (in_vld) begin
                    hdr_nx = {in_bit, hdr[HDR_W-1:1]};
                    if (cnt == LAST) begin
                        cnt_nx = '0;
                        st_nx  = RX_HEAD;
                        tgt_nx = pick_port(hdr_nx[DIM-1:0], node_id);
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            RX_HEAD: begin
                if (gnt && tx_rdy) begin
                    hdr_nx = {1'b0, hdr[HDR_W-1:1]};
                    if (cnt == LAST) begin
                        cnt_nx = '0;
                        st_nx  = RX_BODY;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            RX_BODY: begin
                if (in_vld && in_rdy && in_eom) st_nx = RX_HDR;
            end
            default: st_nx = RX_HDR;
        endcase
    end

    // outputs
    always_comb begin
        in_rdy = 1'b0;
        req    = 1'b0;
        tx_bit = 1'b0;
        tx_vld = 1'b0;
        tx_eom = 1'b0;
        tgt    = tgt_q;
        unique case (st)
            RX_HDR: begin
                in_rdy = 1'b1;
            end
            RX_HEAD: begin
                req    = 1'b1;
                tx_vld = gnt;
                tx_bit = hdr[0];
            end
            RX_BODY: begin
                req    = 1'b1;
                tx_vld = in_vld && gnt;
                tx_bit = in_bit;
                tx_eom = in_eom;
                in_rdy = gnt && tx_rdy;
            end
            default: begin
                in_rdy = 1'b0;
            end
        endcase
    end

    AST_GNT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (st != RX_HDR)) else $error("grant seen by idle input"); // R6

    AST_HDR_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_HDR && in_vld && cnt != LAST) |=> (st == RX_HDR && in_rdy)) else $error("header stall"); // R12

endmodule

// File: rtl/hcr_out_chan.sv
module hcr_out_chan
    import hcr_pkg::*;
#(
    parameter int NP = 4,
    parameter int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req_hit,
    input  logic [NP-1:0] tx_bit_v,
    input  logic [NP-1:0] tx_vld_v,
    input  logic [NP-1:0] tx_eom_v,
    output logic          o_bit,
    output logic          o_vld,
    output logic          o_eom,
    input  logic          o_rdy,
    output logic          busy,
    output logic [PW-1:0] owner
);

    out_state_e    st, st_nx;
    logic [PW-1:0] own_q, own_nx;
    logic [PW-1:0] last_q, last_nx;
    logic [PW-1:0] pick;
    logic          found;
    logic          end_x;

    // round-robin search starting after the previous owner
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NP; k++) begin
            logic [PW-1:0] idx;
            idx = PW'((int'(last_q) + k) % NP);
            if (!found && req_hit[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= OUT_FREE;
            own_q  <= '0;
            last_q <= PW'(NP - 1);
        end else begin
            st     <= st_nx;
            own_q  <= own_nx;
            last_q <= last_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        own_nx  = own_q;
        last_nx = last_q;
        unique case (st)
            OUT_FREE: begin
                if (found) begin
                    st_nx   = OUT_HELD;
                    own_nx  = pick;
                    last_nx = pick;
                end
            end
            OUT_HELD: begin
                if (end_x) st_nx = OUT_FREE;
            end
            default: st_nx = OUT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = (st == OUT_HELD);
        owner = own_q;
        o_vld = busy && tx_vld_v[own_q];
        o_bit = busy && tx_bit_v[own_q];
        o_eom = busy && tx_eom_v[own_q];
        end_x = o_vld && o_rdy && o_eom;
    end

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !end_x) |=> (busy && $stable(owner))) else $error("owner changed mid message"); // R6

    AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && !o_rdy) |=> (o_vld && $stable(o_bit) && $stable(o_eom))) else $error("bit dropped under stall"); // R8

endmodule

// File: rtl/hcube_router.sv
module hcube_router
    import hcr_pkg::*;
#(
    parameter int DIM   = 3,
    parameter int HDR_W = 36
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIM-1:0] node_id,
    input  logic [DIM-1:0] lk_in_bit,
    input  logic [DIM-1:0] lk_in_vld,
    input  logic [DIM-1:0] lk_in_eom,
    output logic [DIM-1:0] lk_in_rdy,
    output logic [DIM-1:0] lk_out_bit,
    output logic [DIM-1:0] lk_out_vld,
    output logic [DIM-1:0] lk_out_eom,
    input  logic [DIM-1:0] lk_out_rdy,
    input  logic           inj_bit,
    input  logic           inj_vld,
    input  logic           inj_eom,
    output logic           inj_rdy,
    output logic           ej_bit,
    output logic           ej_vld,
    output logic           ej_eom,
    input  logic           ej_rdy
);

    localparam int NP = DIM + 1;
    localparam int PW = $clog2(NP);

    logic [NP-1:0] p_in_bit, p_in_vld, p_in_eom, p_in_rdy;
    logic [NP-1:0] p_o_bit, p_o_vld, p_o_eom, p_o_rdy;
    logic [NP-1:0] req, gnt, tx_rdy;
    logic [NP-1:0] tx_bit, tx_vld, tx_eom;
    logic [NP-1:0] busy;
    logic [PW-1:0] tgt   [NP];
    logic [PW-1:0] owner [NP];
    logic [NP-1:0] hit   [NP];
    logic [NP-1:0] gcol  [NP];

    assign p_in_bit = {inj_bit, lk_in_bit};
    assign p_in_vld = {inj_vld, lk_in_vld};
    assign p_in_eom = {inj_eom, lk_in_eom};
    assign lk_in_rdy = p_in_rdy[DIM-1:0];
    assign inj_rdy   = p_in_rdy[DIM];

    assign lk_out_bit = p_o_bit[DIM-1:0];
    assign lk_out_vld = p_o_vld[DIM-1:0];
    assign lk_out_eom = p_o_eom[DIM-1:0];
    assign ej_bit     = p_o_bit[DIM];
    assign ej_vld     = p_o_vld[DIM];
    assign ej_eom     = p_o_eom[DIM];
    assign p_o_rdy    = {ej_rdy, lk_out_rdy};

    // request routing and grant return
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                hit[o][i] = req[i] && (tgt[i] == PW'(o));
            end
        end
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                gcol[i][o] = busy[o] && (owner[o] == PW'(i));
            end
            gnt[i]    = |gcol[i];
            tx_rdy[i] = |(gcol[i] & p_o_rdy);
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_in
        hcr_in_chan #(.DIM(DIM), .HDR_W(HDR_W), .PW(PW)) u_in (
            .clk     (clk),
            .rst_n   (rst_n),
            .node_id (node_id),
            .in_bit  (p_in_bit[i]),
            .in_vld  (p_in_vld[i]),
            .in_eom  (p_in_eom[i]),
            .in_rdy  (p_in_rdy[i]),
            .req     (req[i]),
            .tgt     (tgt[i]),
            .gnt     (gnt[i]),
            .tx_bit  (tx_bit[i]),
            .tx_vld  (tx_vld[i]),
            .tx_eom  (tx_eom[i]),
            .tx_rdy  (tx_rdy[i])
        );

        AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gcol[i])) else $error("input owns two outputs"); // R6
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        hcr_out_chan #(.NP(NP), .PW(PW)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_hit  (hit[o]),
            .tx_bit_v (tx_bit),
            .tx_vld_v (tx_vld),
            .tx_eom_v (tx_eom),
            .o_bit    (p_o_bit[o]),
            .o_vld    (p_o_vld[o]),
            .o_eom    (p_o_eom[o]),
            .o_rdy    (p_o_rdy[o]),
            .busy     (busy[o]),
            .owner    (owner[o])
        );
    end

endmodule

// File: tb/sim_hcube_router.sv
module sim_hcube_router;

    localparam int CLK_NS = 10;
    localparam int DIM    = 3;
    localparam int NP     = DIM + 1;
    localparam int HW     = 36;
    localparam int WD     = 100000;
    localparam logic [DIM-1:0] NODE = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    logic [NP-1:0] in_bit_v = '0, in_vld_v = '0, in_eom_v = '0;
    logic [NP-1:0] in_rdy_v;
    logic [NP-1:0] out_bit_v, out_vld_v, out_eom_v;
    logic [NP-1:0] out_rdy_v = '1;

    hcube_router #(.DIM(DIM), .HDR_W(HW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .node_id    (NODE),
        .lk_in_bit  (in_bit_v[DIM-1:0]),
        .lk_in_vld  (in_vld_v[DIM-1:0]),
        .lk_in_eom  (in_eom_v[DIM-1:0]),
        .lk_in_rdy  (in_rdy_v[DIM-1:0]),
        .lk_out_bit (out_bit_v[DIM-1:0]),
        .lk_out_vld (out_vld_v[DIM-1:0]),
        .lk_out_eom (out_eom_v[DIM-1:0]),
        .lk_out_rdy (out_rdy_v[DIM-1:0]),
        .inj_bit    (in_bit_v[DIM]),
        .inj_vld    (in_vld_v[DIM]),
        .inj_eom    (in_eom_v[DIM]),
        .inj_rdy    (in_rdy_v[DIM]),
        .ej_bit     (out_bit_v[DIM]),
        .ej_vld     (out_vld_v[DIM]),
        .ej_eom     (out_eom_v[DIM]),
        .ej_rdy     (out_rdy_v[DIM])
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rdy_mode = 0;

    int hdr_done [NP];
    int first_cyc [NP];
    int rx_len [NP];
    int rx_cnt [NP];
    logic [127:0] rx_buf [NP];
    logic [127:0] rx_msg [NP][4];
    int rx_mlen [NP][4];

    always @(posedge clk) cyc <= cyc + 1;

    // ready pattern for the eject port
    always begin
        @(negedge clk);
        case (rdy_mode)
            1: out_rdy_v[DIM] = (cyc % 3) != 0;
            2: out_rdy_v[DIM] = 1'b0;
            default: out_rdy_v[DIM] = 1'b1;
        endcase
    end

    // output monitor
    initial begin
        for (int o = 0; o < NP; o++) begin
            rx_len[o] = 0; rx_cnt[o] = 0; rx_buf[o] = '0; first_cyc[o] = 0; hdr_done[o] = 0;
        end
    end
    always begin
        @(negedge clk);
        #2;
        for (int o = 0; o < NP; o++) begin
            if (rst_n && out_vld_v[o] && out_rdy_v[o]) begin
                if (rx_len[o] == 0) begin
                    rx_buf[o] = '0;
                    first_cyc[o] = cyc;
                end
                if (rx_len[o] < 128) rx_buf[o][rx_len[o]] = out_bit_v[o];
                rx_len[o] = rx_len[o] + 1;
                if (out_eom_v[o]) begin
                    rx_msg[o][rx_cnt[o] % 4] = rx_buf[o];
                    rx_mlen[o][rx_cnt[o] % 4] = rx_len[o];
                    rx_cnt[o] = rx_cnt[o] + 1;
                    rx_len[o] = 0;
                end
            end
        end
    end

    task automatic chk_int(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic chk_vec(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [DIM-1:0] d, input int tag, input int len);
        logic [127:0] m;
        m = {32'(tag) * 32'h9E3779B1, (32'(tag) * 32'h85EBCA6B) ^ 32'h0F0F1234,
             32'(tag) * 32'hC2B2AE35, (32'(tag) * 32'h27D4EB2F) ^ 32'hA5A5A5A5};
        m[DIM-1:0] = d;
        for (int b = len; b < 128; b++) m[b] = 1'b0;
        return m;
    endfunction

    task automatic send(input int p, input logic [127:0] m, input int len, input bit eom_hdr);
        int b;
        b = 0;
        while (b < len) begin
            @(negedge clk);
            in_bit_v[p] = m[b];
            in_vld_v[p] = 1'b1;
            in_eom_v[p] = (b == len - 1) || (eom_hdr && b == 5);
            #1;
            if (in_rdy_v[p]) begin
                if (b == HW - 1) hdr_done[p] = cyc;
                b++;
            end
        end
        @(negedge clk);
        in_vld_v[p] = 1'b0;
        in_eom_v[p] = 1'b0;
    endtask

    task automatic wait_rx(input int o, input int n);
        while (rx_cnt[o] < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_msg(input string rq, input int o, input int k, input logic [127:0] m, input int len);
        chk_int(rq, rx_mlen[o][k % 4], len);
        chk_vec(rq, rx_msg[o][k % 4], m);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk); #2;
        chk_int("R1 out valid", int'(out_vld_v), 0);
        chk_int("R1 in ready", int'(in_rdy_v), (1 << NP) - 1);
    endtask

    task automatic t_eject();
        logic [127:0] m;
        int n0, d;
        m = mk(NODE, 11, 60);
        n0 = rx_cnt[DIM];
        send(DIM, m, 60, 1'b0);
        wait_rx(DIM, n0 + 1);
        expect_msg("R2/R4 eject", DIM, n0, m, 60);
        d = first_cyc[DIM] - hdr_done[DIM];
        chk_int("R5 cut-through latency", int'(d >= 1 && d <= 2), 1);
    endtask

    task automatic t_dimorder();
        logic [127:0] m;
        int n0;
        // differs in bits 1,2 -> link 1
        m = mk(NODE ^ 3'b110, 21, 50); n0 = rx_cnt[1];
        send(DIM, m, 50, 1'b0); wait_rx(1, n0 + 1);
        expect_msg("R3 link1", 1, n0, m, 50);
        // differs in bits 0,2 -> link 0
        m = mk(NODE ^ 3'b101, 22, 45); n0 = rx_cnt[0];
        send(0, m, 45, 1'b0); wait_rx(0, n0 + 1);
        expect_msg("R3 link0", 0, n0, m, 45);
        // differs in bit 2 only -> link 2
        m = mk(NODE ^ 3'b100, 23, 70); n0 = rx_cnt[2];
        send(2, m, 70, 1'b0); wait_rx(2, n0 + 1);
        expect_msg("R3 link2", 2, n0, m, 70);
    endtask

    task automatic t_concurrent();
        logic [127:0] ma, mb;
        int na, nb;
        ma = mk(NODE ^ 3'b010, 31, 64);
        mb = mk(NODE ^ 3'b100, 32, 64);
        na = rx_cnt[1]; nb = rx_cnt[2];
        fork
            send(0, ma, 64, 1'b0);
            send(1, mb, 64, 1'b0);
        join
        wait_rx(1, na + 1); wait_rx(2, nb + 1);
        expect_msg("R9 path a", 1, na, ma, 64);
        expect_msg("R9 path b", 2, nb, mb, 64);
        chk_int("R9 same start", first_cyc[1], first_cyc[2]);
    endtask

    task automatic t_round_robin();
        logic [127:0] ma, m0, m2;
        int n0;
        ma = mk(NODE, 41, 40);
        n0 = rx_cnt[DIM];
        send(1, ma, 40, 1'b0);
        wait_rx(DIM, n0 + 1);
        m0 = mk(NODE, 42, 55);
        m2 = mk(NODE, 43, 48);
        fork
            send(0, m0, 55, 1'b0);
            send(2, m2, 48, 1'b0);
        join
        wait_rx(DIM, n0 + 3);
        // previous owner input 1 -> input 2 first, then input 0
        expect_msg("R7 first winner", DIM, n0 + 1, m2, 48);
        expect_msg("R6/R7 second intact", DIM, n0 + 2, m0, 55);
    endtask

    task automatic t_backpressure();
        logic [127:0] m;
        int n0;
        logic held_bit;
        m = mk(NODE, 51, 90);
        n0 = rx_cnt[DIM];
        rdy_mode = 1;
        send(DIM, m, 90, 1'b0);
        wait_rx(DIM, n0 + 1);
        rdy_mode = 0;
        expect_msg("R8 toggled ready", DIM, n0, m, 90);
        m = mk(NODE, 52, 66);
        rdy_mode = 2;
        fork
            send(DIM, m, 66, 1'b0);
            begin
                repeat (60) @(negedge clk);
                #2;
                chk_int("R8 valid held", int'(out_vld_v[DIM]), 1);
                held_bit = out_bit_v[DIM];
                @(negedge clk); #2;
                chk_int("R8 bit stable", int'(out_bit_v[DIM]), int'(held_bit));
                chk_int("R8 inject stalled", int'(in_rdy_v[DIM]), 0);
                rdy_mode = 0;
            end
        join
        wait_rx(DIM, n0 + 2);
        expect_msg("R8 held ready", DIM, n0 + 1, m, 66);
    endtask

    task automatic t_segments();
        logic [127:0] ma, mb;
        int na, nb;
        ma = mk(NODE ^ 3'b001, 61, 44);
        mb = mk(NODE, 62, 52);
        na = rx_cnt[0]; nb = rx_cnt[DIM];
        send(DIM, ma, 44, 1'b0);
        send(DIM, mb, 52, 1'b0);
        wait_rx(0, na + 1); wait_rx(DIM, nb + 1);
        expect_msg("R10 segment one", 0, na, ma, 44);
        expect_msg("R10 segment two", DIM, nb, mb, 52);
    endtask

    task automatic t_hdr_eom();
        logic [127:0] m;
        int n0;
        m = mk(NODE ^ 3'b110, 71, 58);
        n0 = rx_cnt[1];
        send(2, m, 58, 1'b1);
        wait_rx(1, n0 + 1);
        expect_msg("R11 header marker ignored", 1, n0, m, 58);
        chk_int("R11 single message", rx_cnt[1], n0 + 1);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_eject();
        t_dimorder();
        t_concurrent();
        t_round_robin();
        t_backpressure();
        t_segments();
        t_hdr_eom();
        repeat (5) @(negedge clk);
        report();
        $finish;
    end

endmodule